// File: doc/BRIEF.md
# Guarded Flash Control Register

An 8-bit control register placed in front of an on-chip flash controller. Software uses it to open the CPU rewrite path, to pick one of two erase/write modes, to stop the flash (low-power state that also re-initialises the controller), to abort a running erase/write sequence, and to enable three flash interrupt sources.

The register does not simply store whatever value is written. Rewrite enable is only granted after a two-step unlock: a write with the bit at 0 immediately followed by a write with the bit at 1. The stop and abort requests are checked against the controller's live ready/busy status. Leaving rewrite mode is refused while a ready or access-error interrupt request is still pending. A refused field keeps its old value, and the other fields of the same write still update. A sticky flag records an unlock attempt that was refused.

Top module: `flash_ctl_guard`

## Requirements
- R1: While `rst` is high and after its release, the register reads 0x00 and every output is 0.
- R2: `rewrite_en` (bit 1) becomes 1 only on a write with bit 1 = 1 whose immediately preceding bus access was a write with bit 1 = 0.
- R3: `bus_rdata` is combinational and returns {ready-int enable, access-error-int enable, error-int enable, 0, stop, mode, rewrite enable, 0} in bits 7 down to 0, so bits 0 and 4 always read 0.
- R4: A write with bit 4 = 1 makes `seq_reset` high for exactly the next cycle when `rewrite_en` is 1 and `flash_ready` is 0 at the write. Under any other condition there is no pulse.
- R5: A write with bit 3 = 1 sets the stop bit only when `rewrite_en` is 1 and `flash_ready` is 1. Otherwise the bit keeps its value. A write with bit 3 = 0 always clears it. `flash_off` equals the stop bit.
- R6: A write with bit 1 = 0 clears `rewrite_en` only when `rdy_pend` and `acc_pend` are both 0. Otherwise rewrite stays enabled.
- R7: `irq_err`, `irq_acc` and `irq_rdy` are registered. Each one equals, one cycle later, its pending input ANDed with enable bit 5, 6 or 7 respectively.
- R8: Bit 2 (mode select, 1 = mode B, shown on `mode_b`) and bits 5 to 7 store the written value on every write. This holds even when another field of the same write is refused.
- R9: `unlock_rejected` becomes 1 after a write with bit 1 = 1 while `rewrite_en` is 0 and the preceding access was not a write of 0 to bit 1. It stays 1 until reset.
- R10: Any read (`bus_rd`), or any write with bit 1 = 1, placed between the 0-write and the 1-write cancels the unlock. The 1-write is then refused as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read strobe (counts as an access) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| flash_ready | input | 1 | Controller status: 1 ready, 0 busy |
| err_pend | input | 1 | Erase/write error interrupt request pending |
| acc_pend | input | 1 | Access-error interrupt request pending |
| rdy_pend | input | 1 | Ready interrupt request pending |
| rewrite_en | output | 1 | CPU rewrite mode enabled |
| mode_b | output | 1 | Erase/write mode select |
| flash_off | output | 1 | Flash stopped; array access blocked, controller held in init |
| seq_reset | output | 1 | One-cycle erase/write sequence reset pulse |
| irq_err | output | 1 | Masked error interrupt |
| irq_acc | output | 1 | Masked access-error interrupt |
| irq_rdy | output | 1 | Masked ready interrupt |
| unlock_rejected | output | 1 | Sticky flag: an unlock write was refused |

## Verification
The hardest state to reach is a sequence-reset pulse. It needs rewrite mode to be open, which takes an unbroken two-write unlock, and then a bit-4 write while the controller reports busy. A second hard case is leaving rewrite mode, which takes a 0-write at a moment when no ready or access-error interrupt is pending. Directed sequences drive the unlock, the busy abort, refused and accepted stop writes, and blocked and permitted exits. Random traffic then biases the pending inputs towards 0 and interleaves reads so that broken unlock sequences occur often.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_IRQ  = 3;
  localparam int B_RW     = 1;
  localparam int B_MODE   = 2;
  localparam int B_STOP   = 3;
  localparam int B_SRST   = 4;
  localparam int B_IE_LO  = 5;
  localparam int B_IE_HI  = B_IE_LO + NUM_IRQ - 1;
endpackage

// File: rtl/fcg_unlock.sv
module fcg_unlock (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic rd,
  input  logic wbit,
  input  logic clear_ok,
  output logic rw_en,
  output logic rejected
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      rw_en    <= 1'b0;
      rejected <= 1'b0;
    end else begin
      if (wr || rd) armed <= wr && !wbit;
      if (wr) begin
        if (wbit) begin
          if (!rw_en) begin
            if (armed) rw_en    <= 1'b1;
            else       rejected <= 1'b1;
          end
        end else if (rw_en && clear_ok) begin
          rw_en <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fcg_ctrl_bits.sv
module fcg_ctrl_bits
  import fcg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic               w_mode,
  input  logic               w_stop,
  input  logic               w_srst,
  input  logic [NUM_IRQ-1:0] w_ien,
  input  logic               rw_en,
  input  logic               ready,
  output logic               mode,
  output logic               stop,
  output logic               srst_pulse,
  output logic [NUM_IRQ-1:0] ien
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= 1'b0;
      stop       <= 1'b0;
      srst_pulse <= 1'b0;
      ien        <= '0;
    end else begin
      srst_pulse <= wr && w_srst && rw_en && !ready;
      if (wr) begin
        mode <= w_mode;
        ien  <= w_ien;
        if (!w_stop)             stop <= 1'b0;
        else if (rw_en && ready) stop <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fcg_irq_mask.sv
module fcg_irq_mask #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend,
  input  logic [N-1:0] ien,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) irq[i] <= 1'b0;
      else     irq[i] <= pend[i] && ien[i];
    end
  end
endmodule

// File: rtl/flash_ctl_guard.sv
module flash_ctl_guard
  import fcg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             flash_ready,
  input  logic             err_pend,
  input  logic             acc_pend,
  input  logic             rdy_pend,
  output logic             rewrite_en,
  output logic             mode_b,
  output logic             flash_off,
  output logic             seq_reset,
  output logic             irq_err,
  output logic             irq_acc,
  output logic             irq_rdy,
  output logic             unlock_rejected
);
  logic               stop_q;
  logic [NUM_IRQ-1:0] ien_q;
  logic [NUM_IRQ-1:0] irq_q;
  logic               unused_wbits;

  assign unused_wbits = bus_wdata[0];

  fcg_unlock u_unlock (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .wbit     (bus_wdata[B_RW]),
    .clear_ok (!rdy_pend && !acc_pend),
    .rw_en    (rewrite_en),
    .rejected (unlock_rejected)
  );

  fcg_ctrl_bits u_bits (
    .clk        (clk),
    .rst        (rst),
    .wr         (bus_wr),
    .w_mode     (bus_wdata[B_MODE]),
    .w_stop     (bus_wdata[B_STOP]),
    .w_srst     (bus_wdata[B_SRST]),
    .w_ien      (bus_wdata[B_IE_HI:B_IE_LO]),
    .rw_en      (rewrite_en),
    .ready      (flash_ready),
    .mode       (mode_b),
    .stop       (stop_q),
    .srst_pulse (seq_reset),
    .ien        (ien_q)
  );

  fcg_irq_mask #(.N(NUM_IRQ)) u_irq (
    .clk  (clk),
    .rst  (rst),
    .pend ({rdy_pend, acc_pend, err_pend}),
    .ien  (ien_q),
    .irq  (irq_q)
  );

  assign irq_err   = irq_q[0];
  assign irq_acc   = irq_q[1];
  assign irq_rdy   = irq_q[2];
  assign flash_off = stop_q;
  assign bus_rdata = {ien_q, 1'b0, stop_q, mode_b, rewrite_en, 1'b0};
endmodule

// File: rtl/fcg_checker.sv
module fcg_checker (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       flash_ready,
  input logic       acc_pend,
  input logic       rdy_pend,
  input logic       rewrite_en,
  input logic       flash_off,
  input logic       seq_reset,
  input logic       irq_rdy,
  input logic       unlock_rejected
);
  always_comb begin
    a_r3_reserved_zero: assert (bus_rdata[0] == 1'b0 && bus_rdata[4] == 1'b0);
  end

  a_r2_unlock_needs_one: assert property (@(posedge clk) disable iff (rst)
    $rose(rewrite_en) |-> $past(bus_wr && bus_wdata[1]));

  a_r4_pulse_needs_busy: assert property (@(posedge clk) disable iff (rst)
    seq_reset |-> $past(bus_wr && bus_wdata[4] && rewrite_en && !flash_ready));

  a_r5_stop_needs_ready: assert property (@(posedge clk) disable iff (rst)
    $rose(flash_off) |-> $past(rewrite_en && flash_ready && bus_wr));

  a_r6_exit_needs_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rewrite_en) |-> $past(!rdy_pend && !acc_pend && bus_wr));

  a_r7_ready_irq_masked: assert property (@(posedge clk) disable iff (rst)
    irq_rdy |-> $past(rdy_pend && bus_rdata[7]));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    unlock_rejected |=> unlock_rejected);
endmodule

bind flash_ctl_guard fcg_checker u_fcg_chk (
  .clk             (clk),
  .rst             (rst),
  .bus_wr          (bus_wr),
  .bus_rd          (bus_rd),
  .bus_wdata       (bus_wdata),
  .bus_rdata       (bus_rdata),
  .flash_ready     (flash_ready),
  .acc_pend        (acc_pend),
  .rdy_pend        (rdy_pend),
  .rewrite_en      (rewrite_en),
  .flash_off       (flash_off),
  .seq_reset       (seq_reset),
  .irq_rdy         (irq_rdy),
  .unlock_rejected (unlock_rejected)
);

// File: tb/flash_ctl_guard_bench.sv
module flash_ctl_guard_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       flash_ready = 1'b1, err_pend = 1'b0, acc_pend = 1'b0, rdy_pend = 1'b0;
  logic       rewrite_en, mode_b, flash_off, seq_reset;
  logic       irq_err, irq_acc, irq_rdy, unlock_rejected;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model of the register
  logic       m_rw, m_mode, m_stop, m_armed, m_rej;
  logic [2:0] m_ien;
  logic       e_pulse;
  logic [2:0] e_irq;

  always #10 clk = ~clk;

  flash_ctl_guard u_flash_ctl_guard (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd();
    return {m_ien, 1'b0, m_stop, m_mode, m_rw, 1'b0};
  endfunction

  task automatic model_reset();
    m_rw = 0; m_mode = 0; m_stop = 0; m_armed = 0; m_rej = 0;
    m_ien = '0; e_pulse = 0; e_irq = '0;
  endtask

  // called at a negedge; one bus cycle, then checks at the next negedge
  task automatic step(input logic wr, input logic rd, input logic [7:0] d);
    logic n_armed;
    bus_wr = wr; bus_rd = rd; bus_wdata = d;
    @(posedge clk);
    e_pulse = wr && d[4] && m_rw && !flash_ready;
    e_irq   = {rdy_pend, acc_pend, err_pend} & m_ien;
    n_armed = m_armed;
    if (wr || rd) n_armed = wr && !d[1];
    if (wr) begin
      if (d[1]) begin
        if (!m_rw) begin
          if (m_armed) m_rw = 1'b1;
          else         m_rej = 1'b1;
        end
      end else if (m_rw && !rdy_pend && !acc_pend) m_rw = 1'b0;
      m_mode = d[2];
      m_ien  = d[7:5];
      if (!d[3]) m_stop = 1'b0;
      else if (e_stop_ok(d)) m_stop = 1'b1;
    end
    m_armed = n_armed;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R3 rdata", bus_rdata, model_rd());
    chk("R2 rewrite_en", {7'd0, rewrite_en}, {7'd0, m_rw});
    chk("R5 flash_off", {7'd0, flash_off}, {7'd0, m_stop});
    chk("R4 seq_reset", {7'd0, seq_reset}, {7'd0, e_pulse});
    chk("R7 irqs", {5'd0, irq_rdy, irq_acc, irq_err}, {5'd0, e_irq});
    chk("R9 unlock_rejected", {7'd0, unlock_rejected}, {7'd0, m_rej});
  endtask

  // the rewrite-enable value seen at the write is the pre-update one; m_rw
  // may already hold the new value, so the stop rule uses the DUT-visible old one
  logic pre_rw;
  function automatic logic e_stop_ok(input logic [7:0] d);
    return d[3] && pre_rw && flash_ready;
  endfunction
  always @(negedge clk) pre_rw <= rewrite_en;

  task automatic unlock();
    step(1, 0, 8'h00);
    step(1, 0, 8'h02);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", bus_rdata, 8'h00);
    chk("R1 reset outputs", {rewrite_en, mode_b, flash_off, seq_reset, irq_err, irq_acc, irq_rdy, unlock_rejected}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", bus_rdata, 8'h00);

    // R9: 1 without preceding 0
    step(1, 0, 8'h02);
    chk("R9 sticky set", {7'd0, unlock_rejected}, 8'h01);
    // R10: read between breaks sequence
    step(1, 0, 8'h00);
    step(0, 1, 8'h00);
    step(1, 0, 8'h02);
    chk("R10 read cancels unlock", {7'd0, rewrite_en}, 8'h00);
    // R2 proper unlock
    unlock();
    chk("R2 unlocked", {7'd0, rewrite_en}, 8'h01);
    // R5 stop refused while busy, R8 other fields still written
    flash_ready = 1'b0;
    step(1, 0, 8'hAE);
    chk("R5 stop refused busy", {7'd0, flash_off}, 8'h00);
    chk("R8 fields written", bus_rdata, 8'hA6);
    // R4 abort while busy
    step(1, 0, 8'h12);
    chk("R4 pulse busy", {7'd0, seq_reset}, 8'h01);
    step(0, 0, 8'h00);
    chk("R4 pulse one cycle", {7'd0, seq_reset}, 8'h00);
    flash_ready = 1'b1;
    step(1, 0, 8'h12);
    chk("R4 no pulse ready", {7'd0, seq_reset}, 8'h00);
    step(1, 0, 8'h0A);
    chk("R5 stop accepted", {7'd0, flash_off}, 8'h01);
    // R6 exit blocked then allowed
    rdy_pend = 1'b1;
    step(1, 0, 8'h00);
    chk("R6 exit blocked", {7'd0, rewrite_en}, 8'h01);
    rdy_pend = 1'b0; acc_pend = 1'b1;
    step(1, 0, 8'h00);
    chk("R6 exit blocked acc", {7'd0, rewrite_en}, 8'h01);
    acc_pend = 1'b0;
    step(1, 0, 8'h00);
    chk("R6 exit allowed", {7'd0, rewrite_en}, 8'h00);
    // R7 masked irqs
    err_pend = 1'b1; acc_pend = 1'b1; rdy_pend = 1'b1;
    step(1, 0, 8'hA0);
    step(0, 0, 8'h00);
    chk("R7 irq masked", {5'd0, irq_rdy, irq_acc, irq_err}, 8'h05);
    err_pend = 1'b0; acc_pend = 1'b0; rdy_pend = 1'b0;

    // random traffic
    void'($urandom(32'h5eed_0077));
    for (int i = 0; i < 1500; i++) begin
      int op;
      logic [7:0] d;
      flash_ready = $urandom_range(0, 1);
      err_pend    = ($urandom_range(0, 3) == 0);
      acc_pend    = ($urandom_range(0, 3) == 0);
      rdy_pend    = ($urandom_range(0, 3) == 0);
      op = $urandom_range(0, 9);
      d  = 8'($urandom);
      if (op < 6)      step(1, 0, d);
      else if (op < 8) step(0, 1, 8'h00);
      else             step(0, 0, 8'h00);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule